// File: doc/BRIEF.md
# Host Mailbox Port Channel

This block is one byte-wide mailbox between a host processor and an embedded controller. On the host side it sits on a simple I/O bus and answers at two addresses: a data port at `BASE_ADDR` and a command port at `BASE_ADDR + CMD_OFFSET`. A host write to either port lands in one shared input byte, raises the input-full flag and records which port was used. A host read of the data port takes the firmware's reply byte, and a host read of the command port returns the status byte.

On the local side, firmware reaches five byte registers through a small register port: data-in, data-out, status, control and a write-one clear strobe register. Two level interrupts tell firmware that input is waiting or that the reply slot is free. A control bit picks how the flags clear. In one mode a firmware read of data-in releases the input slot. In the other mode only explicit write-one pulses release the slots.

Top module: `host_mbox_chan`

## Requirements
- R1: A host write (`host_wr_i` high for one cycle) to the data port or the command port stores `host_wdata_i` in data-in (local offset 0) and sets input-full, status bit 1. A write to any other address changes nothing.
- R2: Status bit 3 is 1 after a host write to the command port and 0 after a host write to the data port.
- R3: A local write to data-out (offset 1) sets output-full, status bit 0. A host read of the data port returns that byte and clears output-full.
- R4: A host read of the command port returns the status byte and leaves every flag unchanged.
- R5: With control bit 2 (clear mode) at 0, a local read of data-in clears input-full.
- R6: With clear mode at 1, a local read of data-in leaves input-full set. In either mode, writing 1 to bit 7 of the clear register (offset 4) clears input-full. The clear register always reads 0.
- R7: Writing 1 to bit 6 of the clear register clears output-full only when clear mode is 1.
- R8: Through a local write to status (offset 2), firmware sets the busy bit (bit 2) and the event bits 7:4. Bits 0, 1 and 3 of such a write are ignored.
- R9: `irq_in_full_o` is high exactly while input-full is 1 and control bit 0 is 1.
- R10: `irq_out_empty_o` is high exactly while output-full is 0 and control bit 1 is 1.
- R11: After reset, status, control, data-in and data-out read 0 and both interrupts are low.
- R12: If a host write and an input-full clear happen in the same cycle, input-full ends up set. If a local data-out write and a host data-port read happen in the same cycle, output-full ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_addr_i | input | ADDR_W | Host I/O address |
| host_wr_i | input | 1 | Host write strobe, one access per cycle high |
| host_rd_i | input | 1 | Host read strobe, one access per cycle high |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, 0 when the address misses |
| loc_addr_i | input | 3 | Local register offset |
| loc_wr_i | input | 1 | Local write strobe |
| loc_rd_i | input | 1 | Local read strobe |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |
| irq_in_full_o | output | 1 | Input-full interrupt level |
| irq_out_empty_o | output | 1 | Output-empty interrupt level |

## Verification
The hardest case to reach is a collision in a single cycle: a host write that arrives on the same edge as a firmware clear of input-full, or a host data-port read on the same edge as a firmware data-out write. Serial bus tasks never overlap, so the bench has a dedicated task that drives the host and local strobes together in one cycle. It then reads status back through both interfaces to show that setting wins over clearing.

// File: rtl/host_mbox_pkg.sv
package host_mbox_pkg;
  localparam int unsigned LOC_AW = 3;

  localparam logic [LOC_AW-1:0] OFS_DIN  = 3'd0;
  localparam logic [LOC_AW-1:0] OFS_DOUT = 3'd1;
  localparam logic [LOC_AW-1:0] OFS_STAT = 3'd2;
  localparam logic [LOC_AW-1:0] OFS_CTRL = 3'd3;
  localparam logic [LOC_AW-1:0] OFS_CLR  = 3'd4;

  localparam int unsigned ST_OBF  = 0;
  localparam int unsigned ST_IBF  = 1;
  localparam int unsigned ST_BUSY = 2;
  localparam int unsigned ST_CMD  = 3;
  localparam int unsigned ST_EVLO = 4;
  localparam int unsigned EV_W    = 4;

  localparam int unsigned CT_IBFIE = 0;
  localparam int unsigned CT_OBEIE = 1;
  localparam int unsigned CT_MODE  = 2;
  localparam int unsigned CT_W     = 3;

  localparam int unsigned CL_OBF = 6;
  localparam int unsigned CL_IBF = 7;

  typedef struct packed {
    logic wr_data;
    logic wr_cmd;
    logic rd_data;
    logic rd_cmd;
  } host_acc_t;
endpackage

// File: rtl/host_mbox_decode.sv
module host_mbox_decode
  import host_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0062,
  parameter int unsigned CMD_OFFSET = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output host_acc_t         acc_o
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = BASE_ADDR + ADDR_W'(CMD_OFFSET);

  logic hit_data, hit_cmd;
  assign hit_data = (addr_i == BASE_ADDR);
  assign hit_cmd  = (addr_i == CMD_ADDR);

  always_comb begin
    acc_o.wr_data = wr_i & hit_data;
    acc_o.wr_cmd  = wr_i & hit_cmd;
    acc_o.rd_data = rd_i & hit_data;
    acc_o.rd_cmd  = rd_i & hit_cmd;
  end
endmodule

// File: rtl/host_mbox_flags.sv
module host_mbox_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_set_i,
  input  logic              in_is_cmd_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_clr_i,
  input  logic              out_set_i,
  input  logic              out_clr_i,
  output logic              in_full_o,
  output logic              out_full_o,
  output logic              cmd_tag_o,
  output logic [DATA_W-1:0] din_o
);
  // set has priority over clear on both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_full_o  <= 1'b0;
      out_full_o <= 1'b0;
      cmd_tag_o  <= 1'b0;
      din_o      <= '0;
    end else begin
      if (in_set_i) begin
        in_full_o <= 1'b1;
        cmd_tag_o <= in_is_cmd_i;
        din_o     <= in_data_i;
      end else if (in_clr_i) begin
        in_full_o <= 1'b0;
      end
      if (out_set_i)      out_full_o <= 1'b1;
      else if (out_clr_i) out_full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/host_mbox_regs.sv
module host_mbox_regs
  import host_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LOC_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CT_W-1:0]   ctrl_o,
  output logic              busy_o,
  output logic [EV_W-1:0]   events_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_wr_o,
  output logic              clr_in_o,
  output logic              clr_out_o
);
  logic wr_ctrl, wr_stat, wr_clr;
  assign wr_ctrl   = wr_i && addr_i == OFS_CTRL;
  assign wr_stat   = wr_i && addr_i == OFS_STAT;
  assign wr_clr    = wr_i && addr_i == OFS_CLR;
  assign dout_wr_o = wr_i && addr_i == OFS_DOUT;
  assign clr_in_o  = wr_clr && wdata_i[CL_IBF];
  assign clr_out_o = wr_clr && wdata_i[CL_OBF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      busy_o   <= 1'b0;
      events_o <= '0;
      dout_o   <= '0;
    end else begin
      if (wr_ctrl) ctrl_o <= wdata_i[CT_W-1:0];
      if (wr_stat) begin
        busy_o   <= wdata_i[ST_BUSY];
        events_o <= wdata_i[ST_EVLO +: EV_W];
      end
      if (dout_wr_o) dout_o <= wdata_i;
    end
  end
endmodule

// File: rtl/host_mbox_chan.sv
module host_mbox_chan
  import host_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0062,
  parameter int unsigned CMD_OFFSET = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  input  logic [2:0]        loc_addr_i,
  input  logic              loc_wr_i,
  input  logic              loc_rd_i,
  input  logic [7:0]        loc_wdata_i,
  output logic [7:0]        loc_rdata_o,
  output logic              irq_in_full_o,
  output logic              irq_out_empty_o
);
  localparam int unsigned DATA_W = 8;

  host_acc_t          acc;
  logic [CT_W-1:0]    ctrl;
  logic               busy, dout_wr, clr_in_req, clr_out_req;
  logic [EV_W-1:0]    events;
  logic [DATA_W-1:0]  dout, din, status;
  logic               in_full, out_full, cmd_tag;
  logic               strict_mode, in_clr, out_clr, din_read;

  host_mbox_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CMD_OFFSET(CMD_OFFSET)
  ) u_dec (
    .addr_i(host_addr_i), .wr_i(host_wr_i), .rd_i(host_rd_i), .acc_o(acc)
  );

  host_mbox_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(loc_wr_i), .addr_i(loc_addr_i), .wdata_i(loc_wdata_i),
    .ctrl_o(ctrl), .busy_o(busy), .events_o(events), .dout_o(dout),
    .dout_wr_o(dout_wr), .clr_in_o(clr_in_req), .clr_out_o(clr_out_req)
  );

  assign strict_mode = ctrl[CT_MODE];
  assign din_read    = loc_rd_i && loc_addr_i == OFS_DIN;
  assign in_clr      = clr_in_req || (din_read && !strict_mode);
  assign out_clr     = acc.rd_data || (clr_out_req && strict_mode);

  host_mbox_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni,
    .in_set_i(acc.wr_data | acc.wr_cmd), .in_is_cmd_i(acc.wr_cmd),
    .in_data_i(host_wdata_i), .in_clr_i(in_clr),
    .out_set_i(dout_wr), .out_clr_i(out_clr),
    .in_full_o(in_full), .out_full_o(out_full), .cmd_tag_o(cmd_tag),
    .din_o(din)
  );

  always_comb begin
    status = '0;
    status[ST_OBF]  = out_full;
    status[ST_IBF]  = in_full;
    status[ST_BUSY] = busy;
    status[ST_CMD]  = cmd_tag;
    status[ST_EVLO +: EV_W] = events;
  end

  always_comb begin
    unique case (loc_addr_i)
      OFS_DIN:  loc_rdata_o = din;
      OFS_DOUT: loc_rdata_o = dout;
      OFS_STAT: loc_rdata_o = status;
      OFS_CTRL: loc_rdata_o = {{(DATA_W-CT_W){1'b0}}, ctrl};
      default:  loc_rdata_o = '0;
    endcase
  end

  always_comb begin
    if (host_addr_i == BASE_ADDR)
      host_rdata_o = dout;
    else if (host_addr_i == BASE_ADDR + ADDR_W'(CMD_OFFSET))
      host_rdata_o = status;
    else
      host_rdata_o = '0;
  end

  assign irq_in_full_o   = in_full & ctrl[CT_IBFIE];
  assign irq_out_empty_o = ~out_full & ctrl[CT_OBEIE];
endmodule

// File: rtl/host_mbox_chan_chk.sv
module host_mbox_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hw_data,
  input logic       hw_cmd,
  input logic       hr_data,
  input logic       hr_cmd,
  input logic       dout_wr,
  input logic       in_clr,
  input logic       din_read,
  input logic       strict_mode,
  input logic       in_full,
  input logic       out_full,
  input logic       cmd_tag
);
  AST_HWR_SETS_IBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_data || hw_cmd) |=> in_full); // R1
  AST_CMD_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_cmd |=> cmd_tag); // R2
  AST_DATA_UNTAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_data |=> !cmd_tag); // R2
  AST_HRD_CLR_OBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_data && !dout_wr) |=> !out_full); // R3
  AST_CMD_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_cmd && !dout_wr && !hw_data && !hw_cmd && !in_clr) |=>
      ($stable(in_full) && $stable(out_full))); // R4
  AST_STRICT_KEEPS_IBF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strict_mode && in_full && din_read && !in_clr) |=> in_full); // R6
  AST_OBF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_wr |=> out_full); // R12
endmodule

bind host_mbox_chan host_mbox_chan_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .hw_data(acc.wr_data), .hw_cmd(acc.wr_cmd),
  .hr_data(acc.rd_data), .hr_cmd(acc.rd_cmd),
  .dout_wr(dout_wr), .in_clr(in_clr), .din_read(din_read),
  .strict_mode(strict_mode), .in_full(in_full), .out_full(out_full),
  .cmd_tag(cmd_tag)
);

// File: tb/host_mbox_chan_tb_top.sv
module host_mbox_chan_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] DP = 16'h0062;
  localparam logic [15:0] CP = 16'h0066;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] host_addr_i = '0;
  logic        host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;
  logic [2:0]  loc_addr_i = '0;
  logic        loc_wr_i = 1'b0, loc_rd_i = 1'b0;
  logic [7:0]  loc_wdata_i = '0;
  logic [7:0]  loc_rdata_o;
  logic        irq_in_full_o, irq_out_empty_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  host_mbox_chan dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic loc_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); loc_addr_i = a; loc_wdata_i = d; loc_wr_i = 1'b1;
    @(negedge clk_i); loc_wr_i = 1'b0;
  endtask

  task automatic loc_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); loc_addr_i = a; loc_rd_i = 1'b1; #1 d = loc_rdata_o;
    @(negedge clk_i); loc_rd_i = 1'b0;
  endtask

  // look at a register without a read strobe
  task automatic loc_peek(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i); loc_addr_i = a; #1 d = loc_rdata_o;
  endtask

  task automatic host_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i); host_addr_i = a; host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk_i); host_wr_i = 1'b0;
  endtask

  task automatic host_rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i); host_addr_i = a; host_rd_i = 1'b1; #1 d = host_rdata_o;
    @(negedge clk_i); host_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    loc_peek(3'd2, v); check("R11 status", v, 8'h00);
    loc_peek(3'd3, v); check("R11 ctrl", v, 8'h00);
    loc_peek(3'd0, v); check("R11 din", v, 8'h00);
    loc_peek(3'd1, v); check("R11 dout", v, 8'h00);
    check("R11 irqs", {6'b0, irq_in_full_o, irq_out_empty_o}, 8'h00);
  endtask

  task automatic t_host_write();
    logic [7:0] v;
    host_wr(16'h0063, 8'hEE);
    loc_peek(3'd2, v); check("R1 miss addr ignored", v, 8'h00);
    host_wr(DP, 8'hA5);
    loc_peek(3'd2, v); check("R1 ibf after data write", v, 8'h02);
    check("R2 data tag 0", {7'b0, v[3]}, 8'h00);
    loc_rd(3'd0, v); check("R1 din value", v, 8'hA5);
    loc_peek(3'd2, v); check("R5 mode0 read clears ibf", v, 8'h00);
    host_wr(CP, 8'h80);
    loc_peek(3'd2, v); check("R2 cmd tag 1", v, 8'h0A);
    loc_rd(3'd0, v); check("R1 cmd byte in din", v, 8'h80);
    host_wr(DP, 8'h11);
    loc_peek(3'd2, v); check("R2 tag back to 0", v, 8'h02);
    loc_rd(3'd0, v);
  endtask

  task automatic t_host_read();
    logic [7:0] v;
    loc_wr(3'd1, 8'h3C);
    host_rd(CP, v); check("R4 status via cmd port", v, 8'h01);
    loc_peek(3'd2, v); check("R4 cmd read keeps obf", v, 8'h01);
    host_rd(DP, v); check("R3 host reads dout", v, 8'h3C);
    loc_peek(3'd2, v); check("R3 host read clears obf", v, 8'h00);
  endtask

  task automatic t_status_bits();
    logic [7:0] v;
    loc_wr(3'd2, 8'hFF);
    loc_peek(3'd2, v); check("R8 fw bits only", v, 8'hF4);
    host_rd(CP, v); check("R8 host sees fw bits", v, 8'hF4);
    loc_wr(3'd2, 8'h00);
    loc_peek(3'd2, v); check("R8 fw bits cleared", v, 8'h00);
  endtask

  task automatic t_strict_mode();
    logic [7:0] v;
    loc_wr(3'd3, 8'h04);
    host_wr(DP, 8'h5A);
    loc_rd(3'd0, v); check("R6 din value", v, 8'h5A);
    loc_peek(3'd2, v); check("R6 mode1 read keeps ibf", v, 8'h02);
    loc_rd(3'd4, v); check("R6 clear reg reads 0", v, 8'h00);
    loc_wr(3'd4, 8'h80);
    loc_peek(3'd2, v); check("R6 bit7 clears ibf", v, 8'h00);
    loc_wr(3'd1, 8'h77);
    loc_wr(3'd4, 8'h40);
    loc_peek(3'd2, v); check("R7 bit6 clears obf in mode1", v, 8'h00);
    loc_wr(3'd3, 8'h00);
    loc_wr(3'd1, 8'h78);
    loc_wr(3'd4, 8'h40);
    loc_peek(3'd2, v); check("R7 bit6 ignored in mode0", v, 8'h01);
    host_wr(DP, 8'h01);
    loc_wr(3'd4, 8'h80);
    loc_peek(3'd2, v); check("R6 bit7 clears ibf in mode0", v, 8'h01);
    host_rd(DP, v);
  endtask

  task automatic t_irqs();
    logic [7:0] v;
    loc_wr(3'd3, 8'h03);
    @(negedge clk_i);
    check("R9 no ibf irq when empty", {7'b0, irq_in_full_o}, 8'h00);
    check("R10 obe irq when empty", {7'b0, irq_out_empty_o}, 8'h01);
    host_wr(DP, 8'h22);
    check("R9 ibf irq", {7'b0, irq_in_full_o}, 8'h01);
    loc_wr(3'd1, 8'h33);
    check("R10 obe irq low when full", {7'b0, irq_out_empty_o}, 8'h00);
    loc_wr(3'd3, 8'h00);
    check("R9 ibf irq masked", {7'b0, irq_in_full_o}, 8'h00);
    host_rd(DP, v);
    check("R10 obe irq masked", {7'b0, irq_out_empty_o}, 8'h00);
    loc_rd(3'd0, v);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    // host write and clear strobe in the same cycle
    @(negedge clk_i);
    host_addr_i = CP; host_wdata_i = 8'h9C; host_wr_i = 1'b1;
    loc_addr_i = 3'd4; loc_wdata_i = 8'h80; loc_wr_i = 1'b1;
    @(negedge clk_i); host_wr_i = 1'b0; loc_wr_i = 1'b0;
    loc_peek(3'd2, v); check("R12 ibf set wins", v, 8'h0A);
    loc_rd(3'd0, v); check("R12 din updated", v, 8'h9C);
    // dout write and host data read in the same cycle
    @(negedge clk_i);
    host_addr_i = DP; host_rd_i = 1'b1;
    loc_addr_i = 3'd1; loc_wdata_i = 8'h44; loc_wr_i = 1'b1;
    @(negedge clk_i); host_rd_i = 1'b0; loc_wr_i = 1'b0;
    host_rd(CP, v); check("R12 obf set wins", v[1:0], 2'b01);
    host_rd(DP, v); check("R12 new dout", v, 8'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_host_write();
    t_host_read();
    t_status_bits();
    t_strict_mode();
    t_irqs();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule